// File: doc/BRIEF.md
# Half-Duplex Channel Access Scheduler

This block decides when a half-duplex Ethernet MAC may begin a transmission. When the MAC raises its transmit request, the scheduler times an inter-frame gap in two phases. In the first phase any carrier seen on the medium sends the count back to zero, so the phase only ends after an unbroken quiet stretch. In the second phase carrier is ignored and the channel is taken when the count runs out. The grant is then issued as a single-cycle pulse.

When the frame in flight ends in a collision, the MAC reports that the jam sequence has been sent. The scheduler then raises its attempt count and waits a random whole number of slot times, using truncated binary exponential backoff. After the wait it runs the full two-phase gap again and grants the retry. A successful frame clears the attempt count. After too many collisions in a row the scheduler gives up: it raises a one-cycle abort flag and returns to idle. Jam generation, serialization and the media interface belong to the surrounding MAC. All time is counted in bit times, marked by a bit-time tick input.

Top module: `hdx_access_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, tx_grant and xs_abort are 0 and attempt_cnt is 0.
- R2: With no carrier present, tx_grant rises exactly GAP_A_BITS + GAP_B_BITS bit ticks after the first clock edge that samples tx_req high in idle. Clock edges without bit_tick do not advance the gap.
- R3: Carrier sampled high during the first gap phase restarts that phase from zero. The grant then comes GAP_A_BITS + GAP_B_BITS bit ticks after the last edge that sampled carrier high.
- R4: Carrier during the second gap phase has no effect. The grant comes at the same edge as it would with no carrier.
- R5: tx_grant is high for exactly one clock cycle for each transmit start.
- R6: A jam_done pulse while a granted frame is pending raises attempt_cnt by one in the following cycle. A jam_done pulse in idle leaves attempt_cnt unchanged.
- R7: After the nth collision, the retry grant comes r*SLOT_BITS + GAP_A_BITS + GAP_B_BITS + 1 bit ticks after the edge that sampled jam_done, with r a whole number where 0 <= r < 2^min(n, MAX_EXP). The backoff count starts only once jam_done is seen.
- R8: A tx_ok pulse while a granted frame is pending clears attempt_cnt to 0 and returns the block to idle. No grant follows unless a new request arrives.
- R9: The jam_done that would make the count reach ATTEMPT_LIMIT instead gives a one-cycle xs_abort pulse in the next cycle, together with attempt_cnt = 0. The block then stays idle, with no grant, until a new request.
- R10: The backoff exponent is capped at MAX_EXP. For every collision from MAX_EXP onward, r stays below 2^MAX_EXP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_tick | input | 1 | One-cycle strobe for each bit time |
| crs | input | 1 | Carrier sense from the medium |
| tx_req | input | 1 | MAC has a frame ready to send |
| jam_done | input | 1 | Pulse: collision seen and jam sequence finished |
| tx_ok | input | 1 | Pulse: current frame sent without collision |
| tx_grant | output | 1 | One-cycle pulse: start transmitting now |
| xs_abort | output | 1 | One-cycle pulse: frame dropped after too many collisions |
| attempt_cnt | output | ATT_W | Collisions suffered by the current frame |

## Verification
The bench places carrier bursts at the edges of both gap phases. A design that failed to restart the first phase would grant too early. One that let carrier hold back the second phase would grant late. It also stalls the bit tick for a long stretch, which shows up any counter that runs on the clock instead of on bit time. Every retry delay is checked against the grid of whole slot times and against the upper bound set by the capped exponent. This catches a wrong mask width, an exponent that keeps growing past the cap, and a missing second gap after backoff. The sixteenth collision is driven to confirm a single abort pulse, a cleared count and no stray grant. A design off by one in the limit would abort one collision early or one late.

// File: rtl/hdx_pkg.sv
package hdx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_IFG1    = 3'd1,
    ST_IFG2    = 3'd2,
    ST_GRANT   = 3'd3,
    ST_BACKOFF = 3'd4,
    ST_ABORT   = 3'd5
  } acc_state_t;

endpackage

// File: rtl/hdx_lfsr.sv
// Free-running Fibonacci shift register used as the backoff random source.
module hdx_lfsr #(
  parameter int           W    = 10,
  parameter logic [W-1:0] TAPS = 10'h240,
  parameter logic [W-1:0] SEED = 10'h001
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] value
);

  logic [W-1:0] sr_q;
  logic         fb;

  always_comb fb = ^(sr_q & TAPS);

  always_ff @(posedge clk) begin
    if (rst) sr_q <= SEED;
    else     sr_q <= {sr_q[W-2:0], fb};
  end

  assign value = sr_q;

endmodule

// File: rtl/hdx_gap_timer.sv
// Two-phase gap counter. Phase A restarts on carrier; phase B ignores it.
module hdx_gap_timer #(
  parameter int GAP_A_BITS = 64,
  parameter int GAP_B_BITS = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_tick,
  input  logic crs,
  input  logic run_a,
  input  logic run_b,
  output logic end_a,
  output logic end_b
);

  localparam int GAP_MAX = (GAP_A_BITS > GAP_B_BITS) ? GAP_A_BITS : GAP_B_BITS;
  localparam int GAP_W   = (GAP_MAX > 1) ? $clog2(GAP_MAX) : 1;
  localparam logic [GAP_W-1:0] LAST_A = GAP_W'(GAP_A_BITS - 1);
  localparam logic [GAP_W-1:0] LAST_B = GAP_W'(GAP_B_BITS - 1);

  logic [GAP_W-1:0] cnt_q;

  always_comb begin
    end_a = run_a && bit_tick && !crs && (cnt_q == LAST_A);
    end_b = run_b && bit_tick && (cnt_q == LAST_B);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (!(run_a || run_b)) begin
      cnt_q <= '0;
    end else if (run_a && crs) begin
      cnt_q <= '0;
    end else if (bit_tick) begin
      if (end_a || end_b) cnt_q <= '0;
      else                cnt_q <= cnt_q + GAP_W'(1);
    end
  end

endmodule

// File: rtl/hdx_backoff.sv
// Loads a masked random slot count and counts it down in slot times.
module hdx_backoff #(
  parameter int RND_W     = 10,
  parameter int EXP_W     = 4,
  parameter int SLOT_BITS = 512
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_tick,
  input  logic             load,
  input  logic [RND_W-1:0] rnd,
  input  logic [EXP_W-1:0] exp_k,
  input  logic             run,
  output logic             expired,
  output logic [RND_W-1:0] slots_left
);

  localparam int SLOT_W = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1;
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOT_BITS - 1);

  logic [RND_W-1:0]  mask;
  logic [RND_W-1:0]  slots_q;
  logic [SLOT_W-1:0] tick_q;

  always_comb begin
    for (int i = 0; i < RND_W; i++) begin
      mask[i] = (i < int'(exp_k));
    end
  end

  always_comb expired = run && (slots_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      slots_q <= '0;
      tick_q  <= '0;
    end else if (load) begin
      slots_q <= rnd & mask;
      tick_q  <= '0;
    end else if (run && (slots_q != '0)) begin
      if (bit_tick) begin
        if (tick_q == SLOT_LAST) begin
          tick_q  <= '0;
          slots_q <= slots_q - RND_W'(1);
        end else begin
          tick_q <= tick_q + SLOT_W'(1);
        end
      end
    end else begin
      tick_q <= '0;
    end
  end

  assign slots_left = slots_q;

endmodule

// File: rtl/hdx_access_ctrl.sv
module hdx_access_ctrl
  import hdx_pkg::*;
#(
  parameter int GAP_A_BITS    = 64,
  parameter int GAP_B_BITS    = 32,
  parameter int SLOT_BITS     = 512,
  parameter int MAX_EXP       = 10,
  parameter int ATTEMPT_LIMIT = 16,
  parameter int ATT_W         = $clog2(ATTEMPT_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_tick,
  input  logic             crs,
  input  logic             tx_req,
  input  logic             jam_done,
  input  logic             tx_ok,
  output logic             tx_grant,
  output logic             xs_abort,
  output logic [ATT_W-1:0] attempt_cnt
);

  localparam int EXP_W = $clog2(MAX_EXP + 1);
  localparam logic [ATT_W-1:0] LAST_TRY = ATT_W'(ATTEMPT_LIMIT - 1);

  acc_state_t       state;
  logic             gap_end_a, gap_end_b;
  logic             bo_load, bo_expired;
  logic [MAX_EXP-1:0] rnd, bo_slots;
  logic [ATT_W-1:0] n_next;
  logic [EXP_W-1:0] bo_k;

  hdx_lfsr #(
    .W    (MAX_EXP),
    .TAPS (MAX_EXP'(10'h240)),
    .SEED (MAX_EXP'(1))
  ) u_rng (
    .clk   (clk),
    .rst   (rst),
    .value (rnd)
  );

  hdx_gap_timer #(
    .GAP_A_BITS (GAP_A_BITS),
    .GAP_B_BITS (GAP_B_BITS)
  ) u_gap (
    .clk      (clk),
    .rst      (rst),
    .bit_tick (bit_tick),
    .crs      (crs),
    .run_a    (state == ST_IFG1),
    .run_b    (state == ST_IFG2),
    .end_a    (gap_end_a),
    .end_b    (gap_end_b)
  );

  always_comb begin
    n_next  = attempt_cnt + ATT_W'(1);
    if (int'(n_next) >= MAX_EXP) bo_k = EXP_W'(MAX_EXP);
    else                         bo_k = EXP_W'(n_next);
    bo_load = (state == ST_GRANT) && jam_done && !tx_ok && (attempt_cnt != LAST_TRY);
  end

  hdx_backoff #(
    .RND_W     (MAX_EXP),
    .EXP_W     (EXP_W),
    .SLOT_BITS (SLOT_BITS)
  ) u_bo (
    .clk        (clk),
    .rst        (rst),
    .bit_tick   (bit_tick),
    .load       (bo_load),
    .rnd        (rnd),
    .exp_k      (bo_k),
    .run        (state == ST_BACKOFF),
    .expired    (bo_expired),
    .slots_left (bo_slots)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      tx_grant    <= 1'b0;
      xs_abort    <= 1'b0;
      attempt_cnt <= '0;
    end else begin
      tx_grant <= 1'b0;
      xs_abort <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (tx_req) state <= ST_IFG1;
        end
        ST_IFG1: begin
          if (gap_end_a) state <= ST_IFG2;
        end
        ST_IFG2: begin
          if (gap_end_b) begin
            state    <= ST_GRANT;
            tx_grant <= 1'b1;
          end
        end
        ST_GRANT: begin
          if (tx_ok) begin
            attempt_cnt <= '0;
            state       <= ST_IDLE;
          end else if (jam_done) begin
            if (attempt_cnt == LAST_TRY) begin
              attempt_cnt <= '0;
              xs_abort    <= 1'b1;
              state       <= ST_ABORT;
            end else begin
              attempt_cnt <= n_next;
              state       <= ST_BACKOFF;
            end
          end
        end
        ST_BACKOFF: begin
          if (bo_expired) state <= ST_IFG1;
        end
        ST_ABORT: begin
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/hdx_access_chk.sv
module hdx_access_chk
  import hdx_pkg::*;
#(
  parameter int ATTEMPT_LIMIT = 16,
  parameter int MAX_EXP       = 10,
  parameter int ATT_W         = 5,
  parameter int EXP_W         = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               tx_req,
  input logic               crs,
  input logic               tx_grant,
  input logic               xs_abort,
  input logic [ATT_W-1:0]   attempt_cnt,
  input acc_state_t         state,
  input logic               p2_end,
  input logic               bo_load,
  input logic [EXP_W-1:0]   bo_k,
  input logic [MAX_EXP-1:0] bo_slots
);

  AST_GRANT_PULSE: assert property (@(posedge clk) disable iff (rst) tx_grant |=> !tx_grant); // R5
  AST_GRANT_AFTER_GAP: assert property (@(posedge clk) disable iff (rst) tx_grant |-> $past(p2_end)); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst) (state == ST_IDLE && !tx_req) |=> state == ST_IDLE); // R8
  AST_IFG1_RESTART: assert property (@(posedge clk) disable iff (rst) (state == ST_IFG1 && crs) |=> state == ST_IFG1); // R3
  AST_IFG2_NO_STALL: assert property (@(posedge clk) disable iff (rst) (state == ST_IFG2) |=> (state == ST_IFG2 || state == ST_GRANT)); // R4
  AST_ABORT_ZERO: assert property (@(posedge clk) disable iff (rst) xs_abort |-> attempt_cnt == '0); // R9
  AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (rst) xs_abort |=> !xs_abort); // R9
  AST_ATTEMPT_BOUND: assert property (@(posedge clk) disable iff (rst) int'(attempt_cnt) < ATTEMPT_LIMIT); // R6
  AST_ATTEMPT_STEP: assert property (@(posedge clk) disable iff (rst)
    !$stable(attempt_cnt) |-> (attempt_cnt == '0 || attempt_cnt == $past(attempt_cnt) + ATT_W'(1))); // R6
  AST_BO_RANGE: assert property (@(posedge clk) disable iff (rst) bo_load |=> (bo_slots >> $past(bo_k)) == '0); // R7
  AST_EXP_CAP: assert property (@(posedge clk) disable iff (rst)
    bo_load |-> (bo_k != '0 && int'(bo_k) <= MAX_EXP)); // R10

endmodule

bind hdx_access_ctrl hdx_access_chk #(
  .ATTEMPT_LIMIT (ATTEMPT_LIMIT),
  .MAX_EXP       (MAX_EXP),
  .ATT_W         (ATT_W),
  .EXP_W         (EXP_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .tx_req      (tx_req),
  .crs         (crs),
  .tx_grant    (tx_grant),
  .xs_abort    (xs_abort),
  .attempt_cnt (attempt_cnt),
  .state       (state),
  .p2_end      (gap_end_b),
  .bo_load     (bo_load),
  .bo_k        (bo_k),
  .bo_slots    (bo_slots)
);

// File: tb/tb_hdx_access_ctrl.sv
`timescale 1ns/1ps
module tb_hdx_access_ctrl;

  localparam int GA    = 16;
  localparam int GB    = 8;
  localparam int SLOT  = 8;
  localparam int MEXP  = 10;
  localparam int LIMIT = 16;
  localparam int AW    = $clog2(LIMIT + 1);
  localparam int GAP   = GA + GB;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_tick = 1'b1;
  logic crs = 1'b0;
  logic tx_req = 1'b0;
  logic jam_done = 1'b0;
  logic tx_ok = 1'b0;
  logic tx_grant, xs_abort;
  logic [AW-1:0] attempt_cnt;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  hdx_access_ctrl #(
    .GAP_A_BITS (GA),
    .GAP_B_BITS (GB),
    .SLOT_BITS  (SLOT),
    .MAX_EXP    (MEXP),
    .ATTEMPT_LIMIT (LIMIT)
  ) dut (
    .clk (clk), .rst (rst), .bit_tick (bit_tick), .crs (crs),
    .tx_req (tx_req), .jam_done (jam_done), .tx_ok (tx_ok),
    .tx_grant (tx_grant), .xs_abort (xs_abort), .attempt_cnt (attempt_cnt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_grant(output int k);
    k = 0;
    for (int i = 1; i <= 20000; i++) begin
      step();
      if (tx_grant) begin
        k = i;
        return;
      end
    end
  endtask

  task automatic start_req();
    tx_req = 1'b1;
    step();
  endtask

  task automatic finish_ok();
    tx_req = 1'b0;
    tx_ok = 1'b1;
    step();
    tx_ok = 1'b0;
    chk(attempt_cnt == 0, "R8 count cleared", int'(attempt_cnt), 0);
    chk(tx_grant == 1'b0, "R8 no grant after success", int'(tx_grant), 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) step();
    chk(tx_grant == 0 && xs_abort == 0 && attempt_cnt == 0, "R1 in reset",
        int'({tx_grant, xs_abort}) + int'(attempt_cnt), 0);
    rst = 1'b0;
    step();
    chk(tx_grant == 0 && xs_abort == 0 && attempt_cnt == 0, "R1 after release",
        int'({tx_grant, xs_abort}) + int'(attempt_cnt), 0);
  endtask

  task automatic t_plain();
    int k;
    start_req();
    wait_grant(k);
    chk(k == GAP, "R2 quiet gap length", k, GAP);
    step();
    chk(tx_grant == 0, "R5 grant one cycle", int'(tx_grant), 0);
    finish_ok();
  endtask

  task automatic t_tick_stall();
    int k;
    bit seen = 1'b0;
    bit_tick = 1'b0;
    start_req();
    for (int i = 0; i < 40; i++) begin
      step();
      if (tx_grant) seen = 1'b1;
    end
    chk(!seen, "R2 no progress without tick", int'(seen), 0);
    bit_tick = 1'b1;
    wait_grant(k);
    chk(k == GAP, "R2 gap counted in ticks", k, GAP);
    finish_ok();
  endtask

  task automatic t_crs_phase_a();
    int k;
    start_req();
    repeat (4) step();
    crs = 1'b1;
    repeat (3) step();
    crs = 1'b0;
    wait_grant(k);
    chk(k == GAP, "R3 first phase restarts on carrier", k, GAP);
    finish_ok();
  endtask

  task automatic t_crs_late_a();
    int k;
    start_req();
    repeat (GA - 2) step();
    crs = 1'b1;
    step();
    crs = 1'b0;
    wait_grant(k);
    chk(k == GAP, "R3 carrier late in first phase", k, GAP);
    finish_ok();
  endtask

  task automatic t_crs_phase_b();
    int k;
    start_req();
    repeat (GA + 1) step();
    crs = 1'b1;
    repeat (4) step();
    crs = 1'b0;
    wait_grant(k);
    chk(k == GAP - GA - 5, "R4 carrier ignored in second phase", k, GAP - GA - 5);
    finish_ok();
  endtask

  task automatic t_jam_idle();
    jam_done = 1'b1;
    step();
    jam_done = 1'b0;
    step();
    chk(attempt_cnt == 0, "R6 jam in idle ignored", int'(attempt_cnt), 0);
    chk(tx_grant == 0, "R6 no grant from idle jam", int'(tx_grant), 0);
  endtask

  task automatic collide(input int n);
    int k, r, lim;
    jam_done = 1'b1;
    step();
    jam_done = 1'b0;
    chk(int'(attempt_cnt) == n, "R6 attempt count step", int'(attempt_cnt), n);
    wait_grant(k);
    lim = 1 << ((n < MEXP) ? n : MEXP);
    r = (k - GAP - 1) / SLOT;
    chk(k >= GAP + 1 && ((k - GAP - 1) % SLOT) == 0, "R7 delay on slot grid", k, GAP + 1 + r * SLOT);
    if (n >= MEXP) chk(r < lim, "R10 capped exponent range", r, lim - 1);
    else           chk(r < lim, "R7 backoff range", r, lim - 1);
  endtask

  task automatic t_retries();
    int k;
    start_req();
    wait_grant(k);
    tx_req = 1'b0;
    for (int n = 1; n <= LIMIT - 1; n++) collide(n);
    finish_ok();
  endtask

  task automatic t_abort();
    int k;
    bit seen = 1'b0;
    start_req();
    wait_grant(k);
    tx_req = 1'b0;
    for (int n = 1; n <= LIMIT - 1; n++) collide(n);
    jam_done = 1'b1;
    step();
    jam_done = 1'b0;
    chk(xs_abort == 1'b1, "R9 abort raised", int'(xs_abort), 1);
    chk(attempt_cnt == 0, "R9 count cleared on abort", int'(attempt_cnt), 0);
    step();
    chk(xs_abort == 1'b0, "R9 abort one cycle", int'(xs_abort), 0);
    for (int i = 0; i < 3 * GAP; i++) begin
      step();
      if (tx_grant) seen = 1'b1;
    end
    chk(!seen, "R9 idle after abort", int'(seen), 0);
    start_req();
    wait_grant(k);
    chk(k == GAP, "R9 fresh request after abort", k, GAP);
    finish_ok();
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_plain();
    t_tick_stall();
    t_crs_phase_a();
    t_crs_late_a();
    t_crs_phase_b();
    t_jam_idle();
    t_retries();
    t_abort();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule